// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block holds the data stack pointer of a small processor core. The stack grows toward lower addresses. The core raises single-cycle request pulses to push one byte, pop one byte, store a return address on a call or interrupt entry, or restore one on a return. For each stack byte the block gives the data-memory address and says whether that byte is a write or a read. The pointer always names the next free location. A push writes at the pointer and then moves it down. A pop moves the pointer up first and then reads.

Return addresses are three bytes wide, so a call or return moves the pointer by three. The block emits the three byte accesses on three consecutive cycles. On a call, the low address byte goes to the highest location. A return reads the bytes back in the reverse order. Software sees the pointer as two byte-wide registers and may overwrite either one. Only the lower `PTR_W` bits are stored. A one-cycle error flag marks any downward step that lands on or below the legal stack floor.

Control is a three-state machine. `ST_IDLE` accepts one request per cycle. A call moves `ST_IDLE -> ST_CALL`, and `ST_CALL` emits the two trailing write bytes before `ST_CALL -> ST_IDLE`. A return moves `ST_IDLE -> ST_RET`, and `ST_RET` emits the two trailing read bytes before `ST_RET -> ST_IDLE`. Single-byte pushes and pops, and register writes, stay in `ST_IDLE`.

Top module: `stk_pointer_unit`

## Requirements
- R1: After reset the pointer reads 0x40FF (`sp_hi`=0x40, `sp_lo`=0xFF), `acc_valid`=0 and `busy`=0.
- R2: A single push request in idle gives, in the same cycle, one write access (`acc_write`=1, `acc_byte`=0) at address SP. The pointer then reads SP-1.
- R3: A single pop request in idle gives, in the same cycle, one read access (`acc_write`=0, `acc_byte`=0) at address SP+1. The pointer then reads SP+1.
- R4: A call request gives write accesses on three consecutive cycles, at SP, SP-1 and SP-2, with `acc_byte` equal to 0, 1 and 2 (0 is the low byte). `busy` is 1 in the second and third cycles, and the pointer then reads SP-3.
- R5: A return request gives read accesses on three consecutive cycles, at SP+1, SP+2 and SP+3, with `acc_byte` equal to 2, 1 and 0. `busy` is 1 in the second and third cycles, and the pointer then reads SP+3.
- R6: `sp_lo` shows pointer bits 7:0 and `sp_hi` shows bits 15:8. Bits at and above `PTR_W` (default 15) read as zero. An accepted write on `wr_lo` or `wr_hi` replaces that byte with `wr_data`.
- R7: `stack_err` is 1 exactly in the cycles with a write access whose resulting pointer is at or below 0x0100.
- R8: While `busy` is 1, all requests and register writes are ignored.
- R9: In idle, at most one action is taken, in this priority order: register write, call, return, push, pop. A cycle with an accepted register write makes no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push one byte |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Store a three-byte return address |
| ret_req | input | 1 | Restore a three-byte return address |
| wr_lo | input | 1 | Write `wr_data` to the pointer low byte |
| wr_hi | input | 1 | Write `wr_data` to the pointer high byte |
| wr_data | input | 8 | Register write data |
| sp_lo | output | 8 | Pointer low byte |
| sp_hi | output | 8 | Pointer high byte, unimplemented bits zero |
| acc_valid | output | 1 | A stack byte access happens this cycle |
| acc_write | output | 1 | 1 for a write, 0 for a read |
| acc_addr | output | 16 | Address of this byte access |
| acc_byte | output | 2 | Return-address byte index (0 low, 2 high) |
| busy | output | 1 | Trailing bytes of a call or return in progress |
| stack_err | output | 1 | This write step lands at or below the floor |

## Verification
If the pointer is off by one, the error shows on `acc_addr` at the very next access, one cycle after the faulty step. It also shows at once on `sp_lo`/`sp_hi`. A state machine stuck in or skipping `ST_CALL` or `ST_RET` shows within three cycles as a wrong `acc_byte` sequence, a wrong `busy` pattern, or a pointer that moved by something other than three. A wrong floor comparison shows as `stack_err` rising one step early or late in a walk down past 0x0102.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALL = 2'd1,
        ST_RET  = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
    parameter int RA_BYTES = 3,
    localparam int BYTE_W  = $clog2(RA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              wr_any,
    output logic              step_dn,
    output logic              step_up,
    output logic [BYTE_W-1:0] byte_idx,
    output logic              busy
);
    import stk_pkg::*;

    localparam logic [BYTE_W-1:0] LAST = BYTE_W'(RA_BYTES - 1);
    localparam logic [BYTE_W-1:0] ONE  = BYTE_W'(1);

    stk_state_e        state_q, state_d;
    logic [BYTE_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        step_dn  = 1'b0;
        step_up  = 1'b0;
        byte_idx = '0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_any) begin
                    state_d = ST_IDLE;
                end else if (call_req) begin
                    step_dn  = 1'b1;
                    byte_idx = '0;
                    cnt_d    = ONE;
                    state_d  = ST_CALL;
                end else if (ret_req) begin
                    step_up  = 1'b1;
                    byte_idx = LAST;
                    cnt_d    = ONE;
                    state_d  = ST_RET;
                end else if (push_req) begin
                    step_dn = 1'b1;
                end else if (pop_req) begin
                    step_up = 1'b1;
                end
            end
            ST_CALL: begin
                busy     = 1'b1;
                step_dn  = 1'b1;
                byte_idx = cnt_q;
                cnt_d    = cnt_q + ONE;
                if (cnt_q == LAST) state_d = ST_IDLE;
            end
            ST_RET: begin
                busy     = 1'b1;
                step_up  = 1'b1;
                byte_idx = LAST - cnt_q;
                cnt_d    = cnt_q + ONE;
                if (cnt_q == LAST) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/stk_reg.sv
module stk_reg #(
    parameter int              PTR_W    = 15,
    parameter logic [PTR_W-1:0] RESET_SP = PTR_W'(16'h40FF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       din,
    input  logic             dec,
    input  logic             inc,
    output logic [PTR_W-1:0] sp
);
    localparam int HI_W = PTR_W - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= RESET_SP;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) sp[7:0]       <= din;
            if (ld_hi) sp[PTR_W-1:8] <= din[HI_W-1:0];
        end else if (dec) begin
            sp <= sp - PTR_W'(1);
        end else if (inc) begin
            sp <= sp + PTR_W'(1);
        end
    end
endmodule

// File: rtl/stk_addr.sv
module stk_addr #(
    parameter int                PTR_W  = 15,
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] FLOOR  = 16'h0100
) (
    input  logic [PTR_W-1:0]  sp,
    input  logic              dec,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              err
);
    logic [PTR_W-1:0] sp_up;

    always_comb begin
        sp_up = sp + PTR_W'(1);
        addr  = inc ? ADDR_W'(sp_up) : ADDR_W'(sp);
        err   = dec && (ADDR_W'(sp) <= FLOOR + ADDR_W'(1));
    end
endmodule

// File: rtl/stk_pointer_unit.sv
module stk_pointer_unit #(
    parameter int               PTR_W    = 15,
    parameter int               ADDR_W   = 16,
    parameter int               RA_BYTES = 3,
    parameter logic [PTR_W-1:0] RESET_SP = PTR_W'(16'h40FF),
    parameter logic [ADDR_W-1:0] FLOOR   = 16'h0100,
    localparam int              BYTE_W   = $clog2(RA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    output logic [7:0]        sp_lo,
    output logic [7:0]        sp_hi,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] acc_byte,
    output logic              busy
    ,output logic             stack_err
);
    logic             ld_lo, ld_hi, dec, inc;
    logic [PTR_W-1:0] sp;

    assign ld_lo = wr_lo && !busy;
    assign ld_hi = wr_hi && !busy;

    stk_ctrl #(.RA_BYTES(RA_BYTES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .call_req (call_req),
        .ret_req  (ret_req),
        .wr_any   (ld_lo || ld_hi),
        .step_dn  (dec),
        .step_up  (inc),
        .byte_idx (acc_byte),
        .busy     (busy)
    );

    stk_reg #(.PTR_W(PTR_W), .RESET_SP(RESET_SP)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .din   (wr_data),
        .dec   (dec),
        .inc   (inc),
        .sp    (sp)
    );

    stk_addr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .FLOOR(FLOOR)) u_addr (
        .sp   (sp),
        .dec  (dec),
        .inc  (inc),
        .addr (acc_addr),
        .err  (stack_err)
    );

    assign acc_valid = dec || inc;
    assign acc_write = dec;
    assign sp_lo     = sp[7:0];
    assign sp_hi     = 8'(sp >> 8);
endmodule

// File: rtl/stk_pointer_chk.sv
module stk_pointer_chk #(
    parameter int PTR_W  = 15,
    parameter int BYTE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        sp_lo,
    input logic [7:0]        sp_hi,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [BYTE_W-1:0] acc_byte,
    input logic              busy,
    input logic              stack_err
);
    localparam logic [15:0] MASK = 16'((32'd1 << PTR_W) - 1);
    logic [15:0] spv;
    assign spv = {sp_hi, sp_lo};

    // R2
    write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write |=> spv == (($past(spv) - 16'd1) & MASK));
    // R3
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> spv == (($past(spv) + 16'd1) & MASK));
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spv & ~MASK) == 16'd0);
    // R7
    err_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |-> acc_valid && acc_write);
    // R8
    busy_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> acc_valid);
    // R4
    call_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && acc_write && acc_byte == BYTE_W'(1) |->
            $past(acc_valid && acc_write && acc_byte == '0));
endmodule

bind stk_pointer_unit stk_pointer_chk #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sp_lo     (sp_lo),
    .sp_hi     (sp_hi),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_byte  (acc_byte),
    .busy      (busy),
    .stack_err (stack_err)
);

// File: tb/stk_pointer_unit_tb.sv
`timescale 1ns/1ps
module stk_pointer_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 0, pop_req = 0, call_req = 0, ret_req = 0;
    logic        wr_lo = 0, wr_hi = 0;
    logic [7:0]  wr_data = 0;
    logic [7:0]  sp_lo, sp_hi;
    logic        acc_valid, acc_write, busy, stack_err;
    logic [15:0] acc_addr;
    logic [1:0]  acc_byte;

    int tests = 0;
    int fails = 0;
    logic [15:0] m;

    always #4 clk = ~clk;

    stk_pointer_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .pop_req(pop_req), .call_req(call_req), .ret_req(ret_req),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .sp_lo(sp_lo), .sp_hi(sp_hi),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_byte(acc_byte), .busy(busy), .stack_err(stack_err)
    );

    // op codes: 0 push, 1 pop, 2 call, 3 return; entry = {op, pointer after}
    localparam logic [19:0] VEC [10] = '{
        {4'd0, 16'h40FE}, {4'd0, 16'h40FD}, {4'd1, 16'h40FE}, {4'd2, 16'h40FB},
        {4'd3, 16'h40FE}, {4'd2, 16'h40FB}, {4'd2, 16'h40F8}, {4'd1, 16'h40F9},
        {4'd3, 16'h40FC}, {4'd0, 16'h40FB}
    };

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_reqs(input logic [3:0] r);
        {ret_req, call_req, pop_req, push_req} = r;
    endtask

    // first_x: extra requests in first cycle; later_x / later_wr: stimulus during busy cycles
    task automatic run_op(input int op, input logic [15:0] exp,
                          input logic [3:0] first_x, input logic [3:0] later_x, input logic later_wr);
        int n;
        logic dn;
        n  = (op >= 2) ? 3 : 1;
        dn = (op == 0 || op == 2);
        @(negedge clk);
        set_reqs(first_x | (4'b1 << op));
        for (int b = 0; b < n; b++) begin
            logic [15:0] ea;
            logic [1:0]  eb;
            if (b > 0) begin
                @(negedge clk);
                set_reqs(later_x);
                wr_lo = later_wr; wr_data = 8'h55;
            end
            #1;
            ea = dn ? m - 16'(b) : m + 16'(b + 1);
            eb = (n == 1) ? 2'd0 : (dn ? 2'(b) : 2'(2 - b));
            chk(acc_valid && acc_write == dn, dn ? "R2/R4 write access" : "R3/R5 read access",
                {14'd0, acc_valid, acc_write}, {14'd0, 1'b1, dn});
            chk(acc_addr == ea, "R2-R5 addr", acc_addr, ea);
            chk(acc_byte == eb, "R4/R5 byte index", 16'(acc_byte), 16'(eb));
            chk(busy == (b > 0), "R4/R5 busy", 16'(busy), 16'(b > 0));
            chk(stack_err == (dn && (m - 16'(b)) <= 16'h0101), "R7 stack_err",
                16'(stack_err), 16'(dn && (m - 16'(b)) <= 16'h0101));
        end
        @(negedge clk);
        set_reqs(4'b0); wr_lo = 0;
        #1;
        chk({sp_hi, sp_lo} == exp, "R2-R5/R8 pointer after", {sp_hi, sp_lo}, exp);
        chk(!acc_valid, "R8 no stray access", 16'(acc_valid), 16'd0);
        m = exp;
    endtask

    task automatic write_sp(input logic [15:0] v);
        @(negedge clk);
        wr_lo = 1; wr_hi = 1; wr_data = v[7:0];
        @(negedge clk);
        wr_lo = 0; wr_hi = 0;
        // both bytes in one cycle would need two data buses; do high separately
        wr_hi = 1; wr_data = v[15:8];
        @(negedge clk);
        wr_hi = 0;
        #1;
        m = v & 16'h7FFF;
        chk({sp_hi, sp_lo} == m, "R6 register write", {sp_hi, sp_lo}, m);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #20;
        @(negedge clk); #1;
        chk({sp_hi, sp_lo} == 16'h40FF, "R1 pointer in reset", {sp_hi, sp_lo}, 16'h40FF);
        rst_n = 1;
        @(negedge clk); #1;
        chk({sp_hi, sp_lo} == 16'h40FF, "R1 reset value", {sp_hi, sp_lo}, 16'h40FF);
        chk(!acc_valid && !busy, "R1 idle", {14'd0, acc_valid, busy}, 16'd0);
        m = 16'h40FF;

        for (int i = 0; i < 10; i++)
            run_op(int'(VEC[i][19:16]), VEC[i][15:0], 4'b0, 4'b0, 1'b0);

        // R6: upper bit reads zero
        write_sp(16'hFF34);
        chk(sp_hi == 8'h7F, "R6 upper bit zero", 16'(sp_hi), 16'h007F);

        // R7: walk down toward the floor
        write_sp(16'h0103);
        run_op(0, 16'h0102, 4'b0, 4'b0, 1'b0);
        run_op(0, 16'h0101, 4'b0, 4'b0, 1'b0);
        run_op(0, 16'h0100, 4'b0, 4'b0, 1'b0);
        write_sp(16'h0103);
        run_op(2, 16'h0100, 4'b0, 4'b0, 1'b0);
        run_op(3, 16'h0103, 4'b0, 4'b0, 1'b0);

        // R8: requests and writes during busy cycles ignored
        write_sp(16'h2000);
        run_op(2, 16'h1FFD, 4'b0, 4'b1111, 1'b1);
        run_op(3, 16'h2000, 4'b0, 4'b0011, 1'b1);

        // R9: call beats return, push, pop; return beats push, pop; push beats pop
        run_op(2, 16'h1FFD, 4'b1011, 4'b0, 1'b0);
        run_op(3, 16'h2000, 4'b0011, 4'b0, 1'b0);
        run_op(0, 16'h1FFF, 4'b0010, 4'b0, 1'b0);

        // R9: register write beats requests, no access in that cycle
        @(negedge clk);
        wr_lo = 1; wr_data = 8'h80; set_reqs(4'b0101);
        #1;
        chk(!acc_valid, "R9 write blocks access", 16'(acc_valid), 16'd0);
        @(negedge clk);
        wr_lo = 0; set_reqs(4'b0);
        #1;
        chk({sp_hi, sp_lo} == 16'h1F80, "R9 write applied", {sp_hi, sp_lo}, 16'h1F80);

        // R1: reset in the middle of a call
        @(negedge clk);
        call_req = 1;
        @(negedge clk);
        call_req = 0; rst_n = 0;
        #1;
        chk(!busy && !acc_valid, "R1 reset aborts call", {14'd0, busy, acc_valid}, 16'd0);
        chk({sp_hi, sp_lo} == 16'h40FF, "R1 reset restores pointer", {sp_hi, sp_lo}, 16'h40FF);
        @(negedge clk);
        rst_n = 1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule